// File: doc/BRIEF.md
# Processor Condition Flags with Save and Restore

This unit keeps the condition state of a processor core. It holds a sticky overflow flag, a two-bit comparison result, a flag that selects one of two character codes, an interrupt-pending flag and a flag that says whether the core runs in normal state or in control state. The instruction sequencer reports each finished result through a strobe, with the class of the instruction and the overflow and comparison outcome. Separate strobes carry the other events: branch-on-overflow, set-mode, I/O completion, interrupt clear and end of instruction.

The three saveable flags are packed into one four-bit status character. The unit offers this character on a save port when one of three events occurs: a supervisor call, an automatic interrupt branch or a subroutine entry. It then clears the flags that the event requires. A supervisor return or a subroutine exit loads the flags back from a character on the restore port. Memory for the character is outside the unit. The unit also decides, at each end of instruction, whether the automatic interrupt branch is taken.

Top module: `cond_state_unit`

## Requirements
- R1: After reset, every flag is zero: overflow, comparison, mode and interrupt-pending. The unit is in control state (`normal_st`=0), and `save_we` and `auto_br` are low.
- R2: Overflow is sticky. An arithmetic (`res_cls`=0) or move (`res_cls`=3) result with `res_ovf`=1 sets it. Later results that report no overflow leave it set.
- R3: A multiply result (`res_cls`=1) never sets overflow, and neither does a compare/logical/other result (`res_cls`=4). A floating-point result (`res_cls`=2) sets it when `res_ovf` or `res_exp_oor` is 1.
- R4: A `br_ovf` strobe clears overflow on the next edge and leaves the comparison and mode flags as they are.
- R5: A result strobe writes `res_cmp` into the comparison flags (00 no result, 01 greater/high, 10 less/low, 11 equal/zero). In a cycle with no result strobe and no save or restore event, the comparison flags hold their value.
- R6: `set_mode` loads `mode_val` into the mode flag.
- R7: The status character has mode in bit 3, overflow in bit 2 and comparison in bits 1:0. The restore port uses the same layout.
- R8: A supervisor call (`svc_call`) or a taken automatic branch raises `save_we` in that cycle with `save_stack`=0. On the next edge, overflow, comparison and mode are cleared and `normal_st` goes to 0.
- R9: A supervisor return (`svc_ret`) loads all three fields from `rest_char` and sets `normal_st` to 1.
- R10: A subroutine entry (`sub_enter`) raises `save_we` with `save_stack`=1. It clears only overflow. If it coincides with a supervisor call or an automatic branch, the control-state entry takes precedence and `save_stack` is 0.
- R11: A subroutine exit (`sub_exit`) loads the three fields from `rest_char` and leaves `normal_st` unchanged. A restore in the same cycle as a save event is ignored.
- R12: `io_done` sets interrupt-pending, and `irq_clr` clears it (set wins). `auto_br` is high in the same cycle exactly when `instr_end` occurs with interrupt-pending set in normal state. Control state inhibits it.
- R13: When a flag update and a save fall in the same cycle, `save_char` shows the flags after the update, and the clearing follows on the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_v | input | 1 | Instruction result strobe |
| res_cls | input | 3 | Result class: 0 arith, 1 multiply, 2 float, 3 move, 4 other |
| res_ovf | input | 1 | Result field overflowed |
| res_exp_oor | input | 1 | Floating exponent out of range |
| res_cmp | input | 2 | Comparison outcome of the result |
| br_ovf | input | 1 | Branch-on-overflow executed |
| set_mode | input | 1 | Set-mode strobe |
| mode_val | input | 1 | Value for the mode flag |
| io_done | input | 1 | I/O completion event |
| irq_clr | input | 1 | Clear interrupt-pending |
| instr_end | input | 1 | End of instruction |
| svc_call | input | 1 | Supervisor-call branch |
| svc_ret | input | 1 | Supervisor return |
| sub_enter | input | 1 | Subroutine entry |
| sub_exit | input | 1 | Subroutine exit |
| rest_char | input | 4 | Status character to restore |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flags | output | 2 | Comparison flags |
| mode_flag | output | 1 | Character-code mode flag |
| irq_pend | output | 1 | Interrupt pending |
| normal_st | output | 1 | 1 normal state, 0 control state |
| auto_br | output | 1 | Automatic interrupt branch taken this cycle |
| save_we | output | 1 | Save the status character this cycle |
| save_stack | output | 1 | Save target: 1 stack, 0 reserved memory |
| save_char | output | 4 | Status character being saved |

## Verification
Two functions can fall in the same cycle: an instruction result that updates the flags, and a save event that must capture the flags and then clear them. The bench drives an arithmetic result with new comparison and overflow together with a supervisor call. It judges `save_char` in that cycle against the updated values, and the flags after the edge against zero. It also provokes a supervisor return followed by an end of instruction with an interrupt pending. There the automatic branch raises the save in the same cycle it is decided, and the bench compares the character with the restored flags.

// File: rtl/cond_state_pkg.sv
package cond_state_pkg;
  localparam int CMP_W    = 2;
  localparam int CHAR_W   = CMP_W + 2;
  localparam int CMP_LSB  = 0;
  localparam int OVF_POS  = CMP_LSB + CMP_W;
  localparam int MODE_POS = OVF_POS + 1;
  localparam int CLS_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ARITH = 3'd0,
    CLS_MULT  = 3'd1,
    CLS_FLOAT = 3'd2,
    CLS_MOVE  = 3'd3,
    CLS_OTHER = 3'd4
  } res_cls_e;

  typedef struct packed {
    logic             mode;
    logic             ovf;
    logic [CMP_W-1:0] cmp;
  } flags_t;
endpackage

// File: rtl/cond_flag_stage.sv
module cond_flag_stage
  import cond_state_pkg::*;
(
  input  flags_t             cur,
  input  logic               res_v,
  input  logic [CLS_W-1:0]   res_cls,
  input  logic               res_ovf,
  input  logic               res_exp_oor,
  input  logic [CMP_W-1:0]   res_cmp,
  input  logic               br_ovf,
  input  logic               set_mode,
  input  logic               mode_val,
  output flags_t             staged
);
  logic ovf_hit;

  always_comb begin
    ovf_hit = 1'b0;
    unique case (res_cls)
      CLS_ARITH, CLS_MOVE: ovf_hit = res_ovf;
      CLS_FLOAT:           ovf_hit = res_ovf | res_exp_oor;
      default:             ovf_hit = 1'b0;
    endcase
  end

  always_comb begin
    staged = cur;
    if (res_v) begin
      staged.cmp = res_cmp;
      staged.ovf = cur.ovf | ovf_hit;
    end
    if (br_ovf)   staged.ovf  = 1'b0;
    if (set_mode) staged.mode = mode_val;
  end
endmodule

// File: rtl/cond_char_codec.sv
module cond_char_codec
  import cond_state_pkg::*;
(
  input  flags_t              to_pack,
  output logic [CHAR_W-1:0]   packed_char,
  input  logic [CHAR_W-1:0]   from_char,
  output flags_t              unpacked
);
  always_comb begin
    packed_char = '0;
    packed_char[MODE_POS] = to_pack.mode;
    packed_char[OVF_POS]  = to_pack.ovf;
    for (int i = 0; i < CMP_W; i++)
      packed_char[CMP_LSB+i] = to_pack.cmp[i];
  end

  always_comb begin
    unpacked.mode = from_char[MODE_POS];
    unpacked.ovf  = from_char[OVF_POS];
    for (int i = 0; i < CMP_W; i++)
      unpacked.cmp[i] = from_char[CMP_LSB+i];
  end
endmodule

// File: rtl/cond_state_unit.sv
module cond_state_unit
  import cond_state_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_v,
  input  logic [2:0]         res_cls,
  input  logic               res_ovf,
  input  logic               res_exp_oor,
  input  logic [1:0]         res_cmp,
  input  logic               br_ovf,
  input  logic               set_mode,
  input  logic               mode_val,
  input  logic               io_done,
  input  logic               irq_clr,
  input  logic               instr_end,
  input  logic               svc_call,
  input  logic               svc_ret,
  input  logic               sub_enter,
  input  logic               sub_exit,
  input  logic [3:0]         rest_char,
  output logic               ovf_flag,
  output logic [1:0]         cmp_flags,
  output logic               mode_flag,
  output logic               irq_pend,
  output logic               normal_st,
  output logic               auto_br,
  output logic               save_we,
  output logic               save_stack,
  output logic [3:0]         save_char
);
  flags_t flags_q, flags_d, staged, restored;
  logic   irq_q, irq_d, normal_q, normal_d;
  logic   flags_en, irq_en, normal_en;
  logic   ctrl_entry, any_save, any_restore;
  logic [CHAR_W-1:0] char_w;

  cond_flag_stage u_stage (
    .cur         (flags_q),
    .res_v       (res_v),
    .res_cls     (res_cls),
    .res_ovf     (res_ovf),
    .res_exp_oor (res_exp_oor),
    .res_cmp     (res_cmp),
    .br_ovf      (br_ovf),
    .set_mode    (set_mode),
    .mode_val    (mode_val),
    .staged      (staged)
  );

  cond_char_codec u_codec (
    .to_pack     (staged),
    .packed_char (char_w),
    .from_char   (rest_char),
    .unpacked    (restored)
  );

  // event decode
  always_comb begin
    auto_br     = instr_end & irq_q & normal_q;
    ctrl_entry  = svc_call | auto_br;
    any_save    = ctrl_entry | sub_enter;
    any_restore = (svc_ret | sub_exit) & ~any_save;
  end

  // next state for the saveable flags
  always_comb begin
    flags_en = res_v | br_ovf | set_mode | any_save | any_restore;
    if (ctrl_entry) begin
      flags_d = '0;
    end else if (sub_enter) begin
      flags_d     = staged;
      flags_d.ovf = 1'b0;
    end else if (any_restore) begin
      flags_d = restored;
    end else begin
      flags_d = staged;
    end
  end

  // next state for interrupt and state flags
  always_comb begin
    irq_en    = io_done | irq_clr;
    irq_d     = io_done ? 1'b1 : 1'b0;
    normal_en = ctrl_entry | (svc_ret & ~any_save);
    normal_d  = ~ctrl_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      irq_q    <= 1'b0;
      normal_q <= 1'b0;
    end else begin
      if (flags_en)  flags_q  <= flags_d;
      if (irq_en)    irq_q    <= irq_d;
      if (normal_en) normal_q <= normal_d;
    end
  end

  assign ovf_flag   = flags_q.ovf;
  assign cmp_flags  = flags_q.cmp;
  assign mode_flag  = flags_q.mode;
  assign irq_pend   = irq_q;
  assign normal_st  = normal_q;
  assign save_we    = any_save;
  assign save_stack = sub_enter & ~ctrl_entry;
  assign save_char  = char_w;
endmodule

// File: rtl/cond_state_chk.sv
module cond_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_v,
  input logic [2:0] res_cls,
  input logic       br_ovf,
  input logic       svc_call,
  input logic       svc_ret,
  input logic       sub_enter,
  input logic       sub_exit,
  input logic       ovf_flag,
  input logic [1:0] cmp_flags,
  input logic       mode_flag,
  input logic       irq_pend,
  input logic       normal_st,
  input logic       auto_br
);
  // R3: multiply cannot raise overflow
  p_mult_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && res_v && res_cls == 3'd1 && !svc_ret && !sub_exit) |=> !ovf_flag);

  // R2: overflow stays set with no clearing event
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !br_ovf && !svc_call && !auto_br && !sub_enter && !svc_ret && !sub_exit)
      |=> ovf_flag);

  // R4: branch-on-overflow clears it
  p_bov_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_ovf && !svc_ret && !sub_exit) |=> !ovf_flag);

  // R5: comparison holds without a writer
  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_v && !svc_call && !auto_br && !svc_ret && !sub_exit) |=> $stable(cmp_flags));

  // R8: control-state entry clears the flags
  p_ctrl_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_call || auto_br) |=> (!ovf_flag && cmp_flags == 2'b00 && !mode_flag && !normal_st));

  // R9: supervisor return enters normal state
  p_ret_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ret && !svc_call && !auto_br && !sub_enter) |=> normal_st);

  // R12: automatic branch only in normal state with a pending interrupt
  p_auto_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    auto_br |-> (normal_st && irq_pend));
endmodule

bind cond_state_unit cond_state_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_v     (res_v),
  .res_cls   (res_cls),
  .br_ovf    (br_ovf),
  .svc_call  (svc_call),
  .svc_ret   (svc_ret),
  .sub_enter (sub_enter),
  .sub_exit  (sub_exit),
  .ovf_flag  (ovf_flag),
  .cmp_flags (cmp_flags),
  .mode_flag (mode_flag),
  .irq_pend  (irq_pend),
  .normal_st (normal_st),
  .auto_br   (auto_br)
);

// File: tb/cond_state_unit_bench.sv
`timescale 1ns/1ps
module cond_state_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_v, res_ovf, res_exp_oor, br_ovf, set_mode, mode_val;
  logic [2:0] res_cls;
  logic [1:0] res_cmp;
  logic       io_done, irq_clr, instr_end, svc_call, svc_ret, sub_enter, sub_exit;
  logic [3:0] rest_char;
  logic       ovf_flag, mode_flag, irq_pend, normal_st, auto_br, save_we, save_stack;
  logic [1:0] cmp_flags;
  logic [3:0] save_char;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_state_unit u_cond_state_unit (
    .clk(clk), .rst_n(rst_n), .res_v(res_v), .res_cls(res_cls), .res_ovf(res_ovf),
    .res_exp_oor(res_exp_oor), .res_cmp(res_cmp), .br_ovf(br_ovf), .set_mode(set_mode),
    .mode_val(mode_val), .io_done(io_done), .irq_clr(irq_clr), .instr_end(instr_end),
    .svc_call(svc_call), .svc_ret(svc_ret), .sub_enter(sub_enter), .sub_exit(sub_exit),
    .rest_char(rest_char), .ovf_flag(ovf_flag), .cmp_flags(cmp_flags),
    .mode_flag(mode_flag), .irq_pend(irq_pend), .normal_st(normal_st),
    .auto_br(auto_br), .save_we(save_we), .save_stack(save_stack), .save_char(save_char)
  );

  // row: res_v, cls, ovf, oor, cmp, bov, setm, mval, exp {mode,ovf,cmp}, req
  typedef struct packed {
    logic       v;
    logic [2:0] cls;
    logic       ovf;
    logic       oor;
    logic [1:0] cmp;
    logic       bov;
    logic       sm;
    logic       mv;
    logic [3:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 4'b0001, 8'd3},  // R3 multiply
    '{1'b1, 3'd4, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 4'b0011, 8'd3},  // R3 other class
    '{1'b1, 3'd0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 4'b0110, 8'd2},  // R2 arith sets
    '{1'b1, 3'd3, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 4'b0101, 8'd2},  // R2 sticky
    '{1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1101, 8'd6},  // R6 set mode
    '{1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 4'b1001, 8'd4},  // R4 bov
    '{1'b1, 3'd2, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 4'b1100, 8'd3},  // R3 float exp
    '{1'b0, 3'd0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 4'b1100, 8'd5},  // R5 hold
    '{1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 4'b0100, 8'd6},  // R6 clear mode
    '{1'b1, 3'd1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 4'b0111, 8'd5}   // R5 equal
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    res_v = 0; res_cls = 3'd4; res_ovf = 0; res_exp_oor = 0; res_cmp = 2'b00;
    br_ovf = 0; set_mode = 0; mode_val = 0; io_done = 0; irq_clr = 0; instr_end = 0;
    svc_call = 0; svc_ret = 0; sub_enter = 0; sub_exit = 0; rest_char = 4'h0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  function automatic logic [3:0] flags();
    return {mode_flag, ovf_flag, cmp_flags};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flags", {28'd0, flags()}, 32'h0);
    chk("R1 state", {irq_pend, normal_st, auto_br, save_we}, 4'b0000);
    @(negedge clk);
    rst_n = 1;
    #1;

    for (int i = 0; i < NV; i++) begin
      res_v = TBL[i].v; res_cls = TBL[i].cls; res_ovf = TBL[i].ovf;
      res_exp_oor = TBL[i].oor; res_cmp = TBL[i].cmp; br_ovf = TBL[i].bov;
      set_mode = TBL[i].sm; mode_val = TBL[i].mv;
      step();
      chk($sformatf("R%0d row%0d", TBL[i].req, i), {28'd0, flags()}, {28'd0, TBL[i].exp});
    end

    // R12: control state inhibits the automatic branch
    io_done = 1;
    step();
    chk("R12 pend set", irq_pend, 1);
    instr_end = 1;
    #1;
    chk("R12 inhibited", auto_br, 0);
    step();

    // R9: supervisor return, char mode1 ovf0 cmp10 (R7 layout)
    svc_ret = 1; rest_char = 4'b1010;
    step();
    chk("R9 flags", {28'd0, flags()}, 32'hA);
    chk("R9 normal", normal_st, 1);

    // R10: subroutine entry after an overflow result
    res_v = 1; res_cls = 3'd0; res_ovf = 1; res_cmp = 2'b01;
    step();
    sub_enter = 1;
    #1;
    chk("R10 save_we/stack", {save_we, save_stack}, 2'b11);
    chk("R7 char", save_char, 4'b1101);
    step();
    chk("R10 only ovf cleared", {28'd0, flags()}, 32'h9);

    // R11: subroutine exit restore, normal kept
    sub_exit = 1; rest_char = 4'b0111;
    step();
    chk("R11 flags", {28'd0, flags()}, 32'h7);
    chk("R11 normal kept", normal_st, 1);

    // R13 with R8: result and supervisor call coincide
    res_v = 1; res_cls = 3'd0; res_ovf = 0; res_cmp = 2'b10; svc_call = 1;
    #1;
    chk("R13 char", save_char, 4'b0110);
    chk("R8 save target", {save_we, save_stack}, 2'b10);
    step();
    chk("R8 cleared", {27'd0, normal_st, flags()}, 32'h0);

    // R12: automatic branch taken in normal state
    svc_ret = 1; rest_char = 4'b1001;
    step();
    instr_end = 1;
    #1;
    chk("R12 auto taken", auto_br, 1);
    chk("R8 auto char", {save_we, save_stack, save_char}, 6'b10_1001);
    step();
    chk("R8 auto cleared", {27'd0, normal_st, flags()}, 32'h0);

    // R12: interrupt clear removes the branch
    irq_clr = 1;
    step();
    chk("R12 pend cleared", irq_pend, 0);
    svc_ret = 1;
    step();
    instr_end = 1;
    #1;
    chk("R12 no branch", auto_br, 0);
    step();

    // R1: reset mid-run
    res_v = 1; res_cls = 3'd0; res_ovf = 1; res_cmp = 2'b11; io_done = 1;
    step();
    rst_n = 0;
    #1;
    chk("R1 async reset", {26'd0, irq_pend, normal_st, flags()}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule